// File: doc/BRIEF.md
# Bulk-Clearable 1024x4 Static Memory

This block is a clocked model of a small static memory of 1024 words, each 4 bits wide, with a 10-bit address. Data enters on its own 4-bit input and leaves on a separate 4-bit output. That output is shown as a value plus an enable flag, which stands in for a three-state driver. The select, write, output-enable and clear controls are all active low, and the block samples every control on the rising clock edge.

The block does reads, writes and a bulk clear. The clear empties the whole array in one accepted cycle. It does not rewrite each location in turn: a per-word presence bit is kept, and the clear drops all of those bits at once. A word whose presence bit is low reads as zero. A write sets that word's presence bit. The output is registered, so read data appears one cycle after the address and controls are sampled. A clear is honoured only while the write control is high and the chip is selected. Any other clear request is refused and leaves the array as it was.

Top module: `clrsram_top`

## Requirements
- R1: After the system reset, dout_en is 0 and dout is 4'b0000, and every one of the 1024 words reads as 4'b0000.
- R2: A write happens at a clock edge where cs_n=0, we_n=0 and clr_n=1, and it stores din at addr. A later read of that address returns the stored value.
- R3: dout_en is 1 in the cycle after an edge where cs_n=0, oe_n=0, we_n=1 and clr_n=1, and dout then carries the addressed word. Otherwise dout_en is 0 and dout is 4'b0000.
- R4: In the cycle after an edge that samples we_n=0, dout_en is 0.
- R5: With cs_n=1, a low we_n writes nothing, and the addressed word keeps its old contents.
- R6: An edge where clr_n=0, cs_n=0 and we_n=1 (an accepted clear) makes every word read as 4'b0000.
- R7: While clr_n is low, the output is disabled (dout_en=0). The first read sampled after an accepted clear is released shows dout_en=1 and dout=4'b0000, two cycles after the clear was first sampled.
- R8: A clear request with we_n=0 or with cs_n=1 is ignored, and no write takes place while clr_n is low. The array contents are unchanged.
- R9: After a clear, a write sets only the addressed word. The other words still read as 4'b0000.
- R10: A write followed in the very next cycle by a read of the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every control is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| clr_n | input | 1 | Bulk-clear request, active low |
| dout | output | 4 | Registered read data; 4'b0000 while disabled |
| dout_en | output | 1 | High when the output would be driven |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a clear and a write. The bench drives clr_n, cs_n and we_n low together with a nonzero din. It then judges that the clear was refused and that no write happened, by reading the addressed word and sweeping the whole array against a shadow copy. The second pair is a write and a read. A write is followed in the very next cycle by a read of the same word. The bench checks that the output stays disabled in the write cycle and then returns the new data.

// File: rtl/clrsram_pkg.sv
package clrsram_pkg;
   // Decoded per-cycle command, produced from the active-low controls.
   typedef struct packed {
      logic wr;
      logic rd;
      logic clr;
   } clrsram_cmd_t;
endpackage

// File: rtl/clrsram_decode.sv
module clrsram_decode
   import clrsram_pkg::*;
(
   input  logic         cs_n,
   input  logic         we_n,
   input  logic         oe_n,
   input  logic         clr_n,
   output clrsram_cmd_t cmd
);
   always_comb begin
      // A clear request blocks writes and reads. It takes effect only when selected with write high.
      cmd.clr = !clr_n && !cs_n && we_n;
      cmd.wr  = clr_n && !cs_n && !we_n;
      cmd.rd  = clr_n && !cs_n && !oe_n && we_n;
   end
endmodule

// File: rtl/clrsram_store.sv
module clrsram_store
   import clrsram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  clrsram_cmd_t      cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              clr_n,
   output logic [DATA_W-1:0] word
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
         $error("clrsram_store: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("clrsram_store: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  valid_q;

   always_ff @(posedge clk) begin
      if (cmd.wr) mem_q[addr] <= din;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  valid_q[i] <= 1'b0;
         else if (cmd.clr)                            valid_q[i] <= 1'b0;
         else if (cmd.wr && addr == ADDR_W'(i))       valid_q[i] <= 1'b1;
      end
   end

   always_comb word = valid_q[addr] ? mem_q[addr] : '0;

   AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n) cmd.clr |=> (valid_q == '0)); // R6
   AST_REFUSED_CLR_STILL: assert property (@(posedge clk) disable iff (!rst_n) (!clr_n && !cmd.clr) |=> $stable(valid_q)); // R8
   AST_WR_MARKS_WORD: assert property (@(posedge clk) disable iff (!rst_n) cmd.wr |=> valid_q[$past(addr)]); // R9
endmodule

// File: rtl/clrsram_rdport.sv
module clrsram_rdport #(
   parameter int DATA_W    = 4,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_en <= 1'b0;
      else        dout_en <= rd;
   end

   generate
      if (IDLE_ZERO) begin : g_zero_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= '0;
            else        dout <= rd ? word : '0;
         end
      end else begin : g_hold_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  dout <= '0;
            else if (rd) dout <= word;
         end
      end
   endgenerate
endmodule

// File: rtl/clrsram_top.sv
module clrsram_top
   import clrsram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              clr_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);
   clrsram_cmd_t      cmd;
   logic [DATA_W-1:0] word;

   clrsram_decode u_dec (
      .cs_n  (cs_n),
      .we_n  (we_n),
      .oe_n  (oe_n),
      .clr_n (clr_n),
      .cmd   (cmd)
   );

   clrsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .addr  (addr),
      .din   (din),
      .clr_n (clr_n),
      .word  (word)
   );

   clrsram_rdport #(.DATA_W(DATA_W), .IDLE_ZERO(1'b1)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd      (cmd.rd),
      .word    (word),
      .dout    (dout),
      .dout_en (dout_en)
   );

   AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n) dout_en |-> ($past(!cs_n) && $past(!oe_n) && $past(we_n) && $past(clr_n))); // R3
   AST_WE_QUIETS: assert property (@(posedge clk) disable iff (!rst_n) $past(!we_n) |-> !dout_en); // R4
   AST_CLR_QUIETS: assert property (@(posedge clk) disable iff (!rst_n) $past(!clr_n) |-> !dout_en); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !dout_en |-> (dout == '0)); // R3
endmodule

// File: tb/clrsram_top_tb_top.sv
module clrsram_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] addr = '0;
   logic [3:0] din = '0;
   logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
   logic [3:0] dout;
   logic       dout_en;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;
   logic [3:0] shadow [1024];

   always #10 clk = ~clk;

   clrsram_top dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
      .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [3:0] pat(int a);
      return 4'((a * 7) + (a >> 5) + 1);
   endfunction

   task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: {en,dout} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic drive(logic [9:0] a, logic [3:0] d, logic c, logic w, logic o, logic r);
      addr = a; din = d; cs_n = c; we_n = w; oe_n = o; clr_n = r;
   endtask

   task automatic rd(int a, logic [3:0] exp, string req);
      @(negedge clk) drive(10'(a), 4'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      @(negedge clk) chk(req, {dout_en, dout}, {1'b1, exp});
   endtask

   task automatic wr(int a, logic [3:0] d);
      @(negedge clk) drive(10'(a), d, 1'b0, 1'b0, 1'b1, 1'b1);
      shadow[a] = d;
      @(negedge clk) drive(10'(a), 4'h0, 1'b1, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic sweep(string req);
      for (int a = 0; a < 1024; a++) rd(a, shadow[a], req);
   endtask

   initial begin
      for (int a = 0; a < 1024; a++) shadow[a] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk) chk("R1 reset output", {dout_en, dout}, 5'b0);
      sweep("R1 empty after reset");

      // R3: read denied by oe_n high, then by cs_n high
      @(negedge clk) drive(10'd3, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1);
      @(negedge clk) chk("R3 oe_n high", {dout_en, dout}, 5'b0);
      drive(10'd3, 4'h0, 1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk) chk("R3 cs_n high", {dout_en, dout}, 5'b0);

      // R2: fill whole array, read back
      for (int a = 0; a < 1024; a++) wr(a, pat(a));
      sweep("R2 pattern readback");

      // R5: write attempt while deselected
      @(negedge clk) drive(10'd9, ~pat(9), 1'b1, 1'b0, 1'b1, 1'b1);
      rd(9, shadow[9], "R5 deselected write ignored");

      // R4 and R10: write then immediate read of same word
      @(negedge clk) drive(10'd17, 4'hA, 1'b0, 1'b0, 1'b0, 1'b1);
      shadow[17] = 4'hA;
      @(negedge clk) begin
         drive(10'd17, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      end
      chk("R4 output off after write", {dout_en, dout}, 5'b0);
      @(negedge clk) chk("R10 write-then-read", {dout_en, dout}, {1'b1, 4'hA});

      // R8: clear requested with we_n low (same cycle as a write request)
      @(negedge clk) drive(10'd33, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk) chk("R8 refused clear output off", {dout_en, dout}, 5'b0);
      drive(10'd33, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      @(negedge clk) chk("R8 no write during clear request", {dout_en, dout}, {1'b1, shadow[33]});
      // R8: clear requested while deselected
      @(negedge clk) drive(10'd34, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge clk) drive(10'd34, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1);
      sweep("R8 contents kept");

      // R6/R7: accepted clear, output off during it, zero two cycles later
      @(negedge clk) drive(10'd17, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int a = 0; a < 1024; a++) shadow[a] = 4'h0;
      @(negedge clk) chk("R7 output off during clear", {dout_en, dout}, 5'b0);
      drive(10'd17, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      @(negedge clk) chk("R7 zero after release", {dout_en, dout}, 5'b10000);
      sweep("R6 all zero after clear");

      // R9: single write after clear
      wr(100, 4'h6);
      rd(100, 4'h6, "R9 written word");
      rd(101, 4'h0, "R9 neighbour above");
      rd(99, 4'h0, "R9 neighbour below");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule